// File: doc/BRIEF.md
# USB Device Event Flag Register

This block holds the sticky interrupt flags of a USB device controller. The device core sends single-cycle pulses for start of frame, bus reset, isochronous CRC error, endpoint underflow, endpoint overflow and STALL sent. Each pulse latches into its own flag bit. A bus-idle timer inside the block raises the suspend flag after a configurable number of consecutive idle clocks. It also tracks a suspended state, and the resume flag is raised from that state when the bus becomes active again.

Software reaches the flag word through two register offsets that return the same read data. A write of ones at one offset clears the matching flags. A write of ones at the other offset sets them. A third offset holds an 8-bit interrupt enable mask. A registered interrupt line is high whenever any enabled flag is set.

Top module: `usb_evt_flags`

## Requirements
- R1: Each event pulse sets its flag at the next clock edge. The bit positions are start of frame = bit 7, bus reset = bit 4, isochronous CRC error = bit 3, underflow = bit 2, overflow = bit 1, STALL sent = bit 0.
- R2: A write to offset 0xA clears every flag whose data bit is 1.
- R3: A write to offset 0xB sets every flag whose data bit is 1.
- R4: A data bit of 0 in a write to 0xA or 0xB leaves that flag unchanged.
- R5: A read of 0xA and a read of 0xB both return the flag word, one cycle after the address is presented.
- R6: After reset the flags, the enable mask and `irq` are all 0.
- R7: The suspend flag (bit 6) sets on the IDLE_CYC-th consecutive clock with `bus_active` low. Any clock with `bus_active` high restarts the count. The timer then enters the suspended state.
- R8: The resume flag (bit 5) sets only when `bus_active` is high in the suspended state. Doing so leaves the suspended state. No new suspend event is raised while the block is suspended.
- R9: When an event pulse and a clear write hit the same bit in one cycle, the flag ends up set.
- R10: Offset 0xE is a read/write enable mask. `irq` equals the OR of (flags AND mask) and changes at the same edge as the flags.
- R11: Reads of any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_active | input | 1 | High when the bus is not idle |
| ev_sof | input | 1 | Start-of-frame received pulse |
| ev_busrst | input | 1 | Bus reset detected pulse |
| ev_crc | input | 1 | Isochronous CRC error pulse |
| ev_unf | input | 1 | IN transaction hit an empty endpoint |
| ev_ovf | input | 1 | OUT transaction hit an endpoint that was not ready |
| ev_stall | input | 1 | STALL handshake sent pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
A vector table drives the following patterns and reads the word back after each one:
- lone event pulses, to tell the bit positions apart;
- pairs of event pulses;
- clear and set writes with mixed masks, to tell a write-one action from a write-zero non-action;
- all-zero writes at both offsets;
- an event that collides with a clear.

Directed tests then check the suspend timer on the exact threshold cycle, one cycle before it, and after an interruption that must restart the count. They also confirm that resume appears only after a suspend and that a long idle stretch inside the suspended state raises nothing new.

// File: rtl/usb_evt_pkg.sv
package usb_evt_pkg;
  localparam int unsigned FLAG_W = 8;
  localparam int unsigned ADDR_W = 4;

  localparam int unsigned BIT_SOF   = 7;
  localparam int unsigned BIT_SUSP  = 6;
  localparam int unsigned BIT_RES   = 5;
  localparam int unsigned BIT_BRST  = 4;
  localparam int unsigned BIT_CRC   = 3;
  localparam int unsigned BIT_UNF   = 2;
  localparam int unsigned BIT_OVF   = 1;
  localparam int unsigned BIT_STALL = 0;

  localparam logic [ADDR_W-1:0] OFS_CLR = 4'hA;
  localparam logic [ADDR_W-1:0] OFS_SET = 4'hB;
  localparam logic [ADDR_W-1:0] OFS_EN  = 4'hE;
endpackage

// File: rtl/usb_idle_timer.sv
module usb_idle_timer #(
  parameter int unsigned IDLE_CYC = 96000
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_active,
  output logic susp_evt,
  output logic res_evt,
  output logic suspended
);
  localparam int unsigned CW = $clog2(IDLE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(IDLE_CYC - 1);

  logic [CW-1:0] cnt;

  // expiry and wake are decoded from the current state; the flag bank latches them
  assign susp_evt = !suspended && !bus_active && (cnt == LAST);
  assign res_evt  = suspended && bus_active;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      suspended <= 1'b0;
    end else begin
      if (bus_active || suspended || susp_evt) cnt <= '0;
      else                                     cnt <= cnt + 1'b1;
      if (susp_evt)     suspended <= 1'b1;
      else if (res_evt) suspended <= 1'b0;
    end
  end
endmodule

// File: rtl/usb_flag_bank.sv
module usb_flag_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] hw_evt,
  input  logic [W-1:0] clr_mask,
  input  logic [W-1:0] set_mask,
  output logic [W-1:0] flags_d,
  output logic [W-1:0] flags_q
);
  // the clear is applied first, so an event in the same cycle keeps the bit set
  assign flags_d = (flags_q & ~clr_mask) | set_mask | hw_evt;

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_d;
  end
endmodule

// File: rtl/usb_evt_flags.sv
module usb_evt_flags
  import usb_evt_pkg::*;
#(
  parameter int unsigned IDLE_CYC = 96000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_active,
  input  logic              ev_sof,
  input  logic              ev_busrst,
  input  logic              ev_crc,
  input  logic              ev_unf,
  input  logic              ev_ovf,
  input  logic              ev_stall,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [FLAG_W-1:0] reg_wdata,
  output logic [FLAG_W-1:0] reg_rdata,
  output logic              irq
);
  logic              susp_evt, res_evt, susp;
  logic [FLAG_W-1:0] hw_evt, clr_mask, set_mask, flags_d, flags_q, en_q, en_d;

  usb_idle_timer #(.IDLE_CYC(IDLE_CYC)) u_idle (
    .clk(clk), .rst(rst), .bus_active(bus_active),
    .susp_evt(susp_evt), .res_evt(res_evt), .suspended(susp)
  );

  always_comb begin
    hw_evt            = '0;
    hw_evt[BIT_SOF]   = ev_sof;
    hw_evt[BIT_SUSP]  = susp_evt;
    hw_evt[BIT_RES]   = res_evt;
    hw_evt[BIT_BRST]  = ev_busrst;
    hw_evt[BIT_CRC]   = ev_crc;
    hw_evt[BIT_UNF]   = ev_unf;
    hw_evt[BIT_OVF]   = ev_ovf;
    hw_evt[BIT_STALL] = ev_stall;
  end

  assign clr_mask = (reg_wr && reg_addr == OFS_CLR) ? reg_wdata : '0;
  assign set_mask = (reg_wr && reg_addr == OFS_SET) ? reg_wdata : '0;
  assign en_d     = (reg_wr && reg_addr == OFS_EN)  ? reg_wdata : en_q;

  usb_flag_bank #(.W(FLAG_W)) u_bank (
    .clk(clk), .rst(rst), .hw_evt(hw_evt), .clr_mask(clr_mask),
    .set_mask(set_mask), .flags_d(flags_d), .flags_q(flags_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= '0;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      en_q <= en_d;
      irq  <= |(flags_d & en_d);
      case (reg_addr)
        OFS_CLR, OFS_SET: reg_rdata <= flags_q;
        OFS_EN:           reg_rdata <= en_q;
        default:          reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/usb_evt_flags_chk.sv
module usb_evt_flags_chk
  import usb_evt_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              bus_active,
  input logic              ev_sof,
  input logic              ev_stall,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [FLAG_W-1:0] reg_wdata,
  input logic [FLAG_W-1:0] hw_evt,
  input logic [FLAG_W-1:0] flags_q,
  input logic [FLAG_W-1:0] en_q,
  input logic              susp,
  input logic              irq
);
  AST_SOF_LATCH: assert property (@(posedge clk) disable iff (rst)
    ev_sof |=> flags_q[BIT_SOF]); // R1
  AST_CLR_WRITE: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == OFS_CLR && hw_evt == '0) |=> ((flags_q & $past(reg_wdata)) == '0)); // R2
  AST_SET_WRITE: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == OFS_SET) |=> ((flags_q & $past(reg_wdata)) == $past(reg_wdata))); // R3
  AST_ZERO_KEEP: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && (reg_addr == OFS_CLR || reg_addr == OFS_SET) && reg_wdata == '0 && hw_evt == '0)
      |=> $stable(flags_q)); // R4
  AST_RES_ONLY_SUSP: assert property (@(posedge clk) disable iff (rst)
    (!susp && !(reg_wr && reg_addr == OFS_SET && reg_wdata[BIT_RES])) |=> !$rose(flags_q[BIT_RES])); // R8
  AST_NO_RESUSPEND: assert property (@(posedge clk) disable iff (rst)
    (susp && !bus_active && !(reg_wr && reg_addr == OFS_SET)) |=> !$rose(flags_q[BIT_SUSP])); // R8
  AST_EVT_BEATS_CLR: assert property (@(posedge clk) disable iff (rst)
    (ev_stall && reg_wr && reg_addr == OFS_CLR) |=> flags_q[BIT_STALL]); // R9
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
    irq == |(flags_q & en_q)); // R10
endmodule

bind usb_evt_flags usb_evt_flags_chk u_chk (.*);

// File: tb/tb_usb_evt_flags.sv
module tb_usb_evt_flags;
  localparam int unsigned IDLE = 16;
  localparam int NV = 12;
  // {sof,busrst,crc,unf,ovf,stall, wr, addr, wdata, expected flags}
  localparam logic [26:0] VEC [NV] = '{
    {6'b100000, 1'b0, 4'h0, 8'h00, 8'h80},
    {6'b000001, 1'b0, 4'h0, 8'h00, 8'h81},
    {6'b000000, 1'b1, 4'hA, 8'h80, 8'h01},
    {6'b000000, 1'b1, 4'hB, 8'h60, 8'h61},
    {6'b000000, 1'b1, 4'hA, 8'h00, 8'h61},
    {6'b000000, 1'b1, 4'hB, 8'h00, 8'h61},
    {6'b011000, 1'b0, 4'h0, 8'h00, 8'h79},
    {6'b000110, 1'b0, 4'h0, 8'h00, 8'h7F},
    {6'b000000, 1'b1, 4'hA, 8'hFF, 8'h00},
    {6'b000000, 1'b1, 4'hB, 8'hFF, 8'hFF},
    {6'b000001, 1'b1, 4'hA, 8'h0F, 8'hF1},
    {6'b000000, 1'b1, 4'hA, 8'hFF, 8'h00}
  };
  localparam logic [7:0] TEN = 8'h81;

  logic clk = 0, rst = 1, bus_active = 1;
  logic ev_sof = 0, ev_busrst = 0, ev_crc = 0, ev_unf = 0, ev_ovf = 0, ev_stall = 0;
  logic reg_wr = 0;
  logic [3:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic irq;
  int total = 0, bad = 0;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  usb_evt_flags #(.IDLE_CYC(IDLE)) dut (
    .clk(clk), .rst(rst), .bus_active(bus_active), .ev_sof(ev_sof), .ev_busrst(ev_busrst),
    .ev_crc(ev_crc), .ev_unf(ev_unf), .ev_ovf(ev_ovf), .ev_stall(ev_stall),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_addr = 0; reg_wdata = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata; reg_addr = 0;
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R6 reset state
    rd(4'hA, rv); chk("R6 flags", rv, 8'h00);
    rd(4'hE, rv); chk("R6 enable", rv, 8'h00);
    chk("R6 irq", {7'b0, irq}, 8'h00);
    wr(4'hE, 8'h20);
    chk("R8 no resume while active and awake", {7'b0, irq}, 8'h00);
    wr(4'hE, TEN);
    rd(4'hE, rv); chk("R10 enable readback", rv, TEN);

    // vector table: R1 R2 R3 R4 R9
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {ev_sof, ev_busrst, ev_crc, ev_unf, ev_ovf, ev_stall} = VEC[i][26:21];
      reg_wr = VEC[i][20]; reg_addr = VEC[i][19:16]; reg_wdata = VEC[i][15:8];
      @(negedge clk);
      {ev_sof, ev_busrst, ev_crc, ev_unf, ev_ovf, ev_stall} = 6'b0;
      reg_wr = 0; reg_addr = 0; reg_wdata = 0;
      chk($sformatf("R10 irq vec%0d", i), {7'b0, irq}, {7'b0, |(VEC[i][7:0] & TEN)});
      rd(4'hA, rv); chk($sformatf("R1/R2/R3/R4/R9 vec%0d", i), rv, VEC[i][7:0]);
    end

    // R5 both aliases, R11 unmapped
    wr(4'hB, 8'h5A);
    rd(4'hA, rv); chk("R5 clear alias read", rv, 8'h5A);
    rd(4'hB, rv); chk("R5 set alias read", rv, 8'h5A);
    rd(4'h3, rv); chk("R11 unmapped read", rv, 8'h00);
    wr(4'hA, 8'hFF);

    // R7 suspend threshold with restart
    wr(4'hE, 8'h40);
    @(negedge clk); bus_active = 0;
    repeat (10) @(negedge clk);
    bus_active = 1;
    @(negedge clk); bus_active = 0;
    repeat (IDLE - 1) @(negedge clk);
    chk("R7 one cycle before threshold", {7'b0, irq}, 8'h00);
    @(negedge clk);
    chk("R7 suspend at threshold", {7'b0, irq}, 8'h01);
    rd(4'hA, rv); chk("R7 suspend bit6", rv, 8'h40);

    // R8 resume from suspended state
    wr(4'hA, 8'hFF);
    wr(4'hE, 8'h60);
    repeat (2 * IDLE) @(negedge clk);
    chk("R8 no flags while suspended and idle", {7'b0, irq}, 8'h00);
    bus_active = 1;
    @(negedge clk);
    chk("R8 resume irq", {7'b0, irq}, 8'h01);
    rd(4'hA, rv); chk("R8 resume bit5", rv, 8'h20);
    wr(4'hA, 8'hFF);
    repeat (4) @(negedge clk);
    rd(4'hA, rv); chk("R8 single resume after wake", rv, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule